// File: doc/BRIEF.md
# Serial Clock-Control Register Loader

This block receives write transactions on a two-wire serial bus (I2C, slave receiver only) and loads a bank of five 8-bit clock-control registers that gate the outputs of a clock generator. The bus lines are oversampled by the system clock. Each line passes through a two-flop synchronizer before the block looks for edges on it. The block recognises START and STOP conditions. It answers to one fixed 7-bit address, and it acknowledges the address byte and every data byte that follows.

After an accepted address, data bytes land in register 0, then register 1, and so on. Each byte is shifted in most significant bit first. A byte is committed only when all eight of its bits are in. Extra bytes past the last register are acknowledged and thrown away. The registers do not share one enable polarity. Registers 0 to 2 use 1 = enabled. Register 3 uses 0 = enabled. Register 4 is a spare byte. The block drives the register contents straight to the rest of the chip.

Top module: `clkcfg_i2c_regs`

## Requirements
- R1: After reset the registers read, from register 0 to register 4: 0x07, 0xFF, 0xFE, 0x00, 0xFF. In register 0, bit 3 is the spread enable and bit 4 is the extended range select.
- R2: For an address byte of 1101001 followed by a write bit of 0 (byte value 0xD2), the block pulls SDA low during the ninth SCL high phase.
- R3: An address byte with any other value is not acknowledged, and this includes 0xD3, the read form. The data bytes that follow it are not acknowledged either, and every register keeps its value.
- R4: The data bytes of a transaction are stored in order, starting at register 0. Bit 7 of each register holds the first bit received. The value is stored exactly as sent, with no polarity change in any register.
- R5: Every data byte of an accepted transaction is acknowledged during its ninth SCL high phase.
- R6: Data bytes past register 4 are acknowledged and leave every register unchanged.
- R7: A STOP received in the middle of a byte leaves every register unchanged.
- R8: A repeated START begins a new address phase. Data that follows it is stored again from register 0.
- R9: A data byte shows on its register output no later than the SCL high phase of its acknowledge bit, which is before any following STOP or START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line, as seen on the bus |
| sda_oe_o | output | 1 | When 1, the block drives SDA low (acknowledge) |
| misc_ctl_o | output | 8 | Register 0: CPU/3V66/PCI0/APIC/SDRAM8 enables, with the spread enable at bit 3 and the range select at bit 4; 1 = enabled |
| sdram_en_o | output | 8 | Register 1: memory clock enables, 1 = enabled |
| pci_en_o | output | 8 | Register 2: bus clock enables in bits 7..1, with bit 0 reserved; 1 = enabled |
| periph_dis_o | output | 8 | Register 3: peripheral clock disables, 0 = enabled |
| spare_o | output | 8 | Register 4: reserved byte |

## Verification
If the bit counter or the shift register holds a wrong value, the fault shows on SDA: the acknowledge comes in the wrong ninth slot, or is missing for 0xD2. It also shows on the registers, where the stored byte is rotated or shifted by one bit or more. Both effects appear within the same byte. If the register index is wrong, the wrong output byte changes, or a sixth byte overwrites one of the first five. This is visible at the stop that ends the transaction. If a byte is committed too early, a STOP in mid-byte leaves a partial value in the register, and that shows straight after the stop.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int unsigned NUM_REGS   = 5;
  localparam int unsigned BYTE_W     = 8;
  localparam int unsigned IDX_W      = $clog2(NUM_REGS + 1);
  localparam int unsigned BITCNT_W   = $clog2(BYTE_W + 1);
  localparam logic [6:0]  SLAVE_ADDR = 7'b1101001;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ACK_A, ST_DATA, ST_ACK_D, ST_IGNORE
  } rx_state_e;

  function automatic logic [BYTE_W-1:0] reg_reset_val(input int unsigned idx);
    case (idx)
      0:       return 8'h07;
      1:       return 8'hFF;
      2:       return 8'hFE;
      3:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_line_sync.sv
module clkcfg_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= line_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q[g] <= 1'b1;
        else         chain_q[g] <= chain_q[g-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= chain_q[STAGES-1];

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;
  assign fall_o  = ~chain_q[STAGES-1] & prev_q;
endmodule

// File: rtl/clkcfg_i2c_rx.sv
module clkcfg_i2c_rx
  import clkcfg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                scl_lvl_i,
  input  logic                scl_rise_i,
  input  logic                scl_fall_i,
  input  logic                sda_lvl_i,
  input  logic                sda_rise_i,
  input  logic                sda_fall_i,
  output logic                sda_oe_o,
  output logic                wr_en_o,
  output logic [IDX_W-1:0]    wr_idx_o,
  output logic [BYTE_W-1:0]   wr_data_o
);
  rx_state_e             state_q;
  logic [BITCNT_W-1:0]   bitcnt_q;
  logic [BYTE_W-1:0]     shreg_q;
  logic [IDX_W-1:0]      idx_q;
  logic                  oe_q;
  logic                  start_det, stop_det, byte_done, addr_hit;

  assign start_det = scl_lvl_i & sda_fall_i;
  assign stop_det  = scl_lvl_i & sda_rise_i;
  assign byte_done = scl_fall_i && (bitcnt_q == BITCNT_W'(BYTE_W));
  assign addr_hit  = (shreg_q[7:1] == SLAVE_ADDR) && !shreg_q[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      bitcnt_q <= '0;
      shreg_q  <= '0;
      idx_q    <= '0;
      oe_q     <= 1'b0;
    end else if (start_det) begin
      state_q  <= ST_ADDR;
      bitcnt_q <= '0;
      idx_q    <= '0;
      oe_q     <= 1'b0;
    end else if (stop_det) begin
      state_q  <= ST_IDLE;
      oe_q     <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_DATA: begin
          if (scl_rise_i && bitcnt_q < BITCNT_W'(BYTE_W)) begin
            shreg_q  <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
            bitcnt_q <= bitcnt_q + 1'b1;
          end else if (byte_done) begin
            if (state_q == ST_ADDR) begin
              state_q <= addr_hit ? ST_ACK_A : ST_IGNORE;
              oe_q    <= addr_hit;
            end else begin
              state_q <= ST_ACK_D;
              oe_q    <= 1'b1;
              if (idx_q < IDX_W'(NUM_REGS)) idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_ACK_A, ST_ACK_D: begin
          if (scl_fall_i) begin
            oe_q     <= 1'b0;
            state_q  <= ST_DATA;
            bitcnt_q <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o  = oe_q;
  assign wr_en_o   = !start_det && !stop_det && (state_q == ST_DATA) && byte_done &&
                     (idx_q < IDX_W'(NUM_REGS));
  assign wr_idx_o  = idx_q;
  assign wr_data_o = shreg_q;

  AST_ACK_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !scl_lvl_i);  // R5
  AST_ACK_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sda_oe_o |-> (state_q == ST_ACK_A || state_q == ST_ACK_D));  // R2
  AST_STOP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> (state_q == ST_IDLE && !sda_oe_o));  // R7
  AST_BITCNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bitcnt_q <= BITCNT_W'(BYTE_W));  // R9
  AST_START_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_det |=> (state_q == ST_ADDR && bitcnt_q == '0 && idx_q == '0));  // R8
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile
  import clkcfg_pkg::*;
(
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [IDX_W-1:0]                  wr_idx_i,
  input  logic [BYTE_W-1:0]                 wr_data_i,
  output logic [NUM_REGS-1:0][BYTE_W-1:0]   regs_o
);
  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)                                    regs_o[g] <= reg_reset_val(g);
      else if (wr_en_i && wr_idx_i == IDX_W'(g))      regs_o[g] <= wr_data_i;
  end

  AST_REG_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(regs_o));  // R3
  AST_WR_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_idx_i == '0) |=> regs_o[0] == $past(wr_data_i));  // R4
endmodule

// File: rtl/clkcfg_i2c_regs.sv
module clkcfg_i2c_regs
  import clkcfg_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  output logic [7:0] misc_ctl_o,
  output logic [7:0] sdram_en_o,
  output logic [7:0] pci_en_o,
  output logic [7:0] periph_dis_o,
  output logic [7:0] spare_o
);
  logic scl_lvl, scl_rise, scl_fall, sda_lvl, sda_rise, sda_fall;
  logic                            wr_en;
  logic [IDX_W-1:0]                wr_idx;
  logic [BYTE_W-1:0]               wr_data;
  logic [NUM_REGS-1:0][BYTE_W-1:0] regs;

  clkcfg_line_sync #(.STAGES(2)) i_scl_sync (
    .clk_i, .rst_ni, .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

  clkcfg_line_sync #(.STAGES(2)) i_sda_sync (
    .clk_i, .rst_ni, .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

  clkcfg_i2c_rx i_rx (
    .clk_i, .rst_ni,
    .scl_lvl_i(scl_lvl), .scl_rise_i(scl_rise), .scl_fall_i(scl_fall),
    .sda_lvl_i(sda_lvl), .sda_rise_i(sda_rise), .sda_fall_i(sda_fall),
    .sda_oe_o, .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data));

  clkcfg_regfile i_regs (
    .clk_i, .rst_ni, .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .regs_o(regs));

  assign misc_ctl_o   = regs[0];
  assign sdram_en_o   = regs[1];
  assign pci_en_o     = regs[2];
  assign periph_dis_o = regs[3];
  assign spare_o      = regs[4];
endmodule

// File: tb/test_clkcfg_i2c_regs.sv
module test_clkcfg_i2c_regs;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;

  typedef struct packed {
    logic [7:0]      addr;
    logic [3:0]      nbytes;
    logic [5:0][7:0] data;
    logic            ack;
    logic [4:0][7:0] exp;
  } vec_t;

  // data[k] / exp[k] index k = byte/register number
  localparam vec_t VECS [5] = '{
    // R2 R4 R5: accepted write of three bytes
    '{8'hD2, 4'd3, {8'h00, 8'h00, 8'h00, 8'h5A, 8'h3C, 8'h1B}, 1'b1,
      {8'hFF, 8'h00, 8'h5A, 8'h3C, 8'h1B}},
    // R3: read form of the address, ignored
    '{8'hD3, 4'd2, {8'h00, 8'h00, 8'h00, 8'h00, 8'hA5, 8'hA5}, 1'b0,
      {8'hFF, 8'h00, 8'h5A, 8'h3C, 8'h1B}},
    // R3: foreign address, ignored
    '{8'hA4, 4'd1, {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}, 1'b0,
      {8'hFF, 8'h00, 8'h5A, 8'h3C, 8'h1B}},
    // R6 R4: six bytes, sixth discarded; register 3 stored unmodified
    '{8'hD2, 4'd6, {8'h66, 8'h55, 8'h44, 8'h33, 8'h22, 8'h11}, 1'b1,
      {8'h55, 8'h44, 8'h33, 8'h22, 8'h11}},
    // R4: new transaction starts at register 0
    '{8'hD2, 4'd1, {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h80}, 1'b1,
      {8'h55, 8'h44, 8'h33, 8'h22, 8'h80}}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_line;
  logic sda_oe;
  logic [7:0] r0, r1, r2, r3, r4;
  int n_chk = 0, n_fail = 0;
  logic done = 1'b0;

  assign sda_line = sda_drv & ~sda_oe;

  clkcfg_i2c_regs i_clkcfg_i2c_regs (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .misc_ctl_o(r0), .sdram_en_o(r1), .pci_en_o(r2),
    .periph_dis_o(r3), .spare_o(r4));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic wait_q(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_regs(input string req, input logic [4:0][7:0] exp);
    chk(req, {24'h0, r0}, {24'h0, exp[0]});
    chk(req, {24'h0, r1}, {24'h0, exp[1]});
    chk(req, {24'h0, r2}, {24'h0, exp[2]});
    chk(req, {24'h0, r3}, {24'h0, exp[3]});
    chk(req, {24'h0, r4}, {24'h0, exp[4]});
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; wait_q(Q);
    scl_drv = 1'b1; wait_q(Q);
    sda_drv = 1'b0; wait_q(Q);
    scl_drv = 1'b0; wait_q(Q);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wait_q(Q);
    scl_drv = 1'b1; wait_q(Q);
    sda_drv = 1'b1; wait_q(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_drv = b[i]; wait_q(Q);
      scl_drv = 1'b1; wait_q(Q);
      scl_drv = 1'b0; wait_q(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    send_bits(b, 8);
    sda_drv = 1'b1; wait_q(Q);
    scl_drv = 1'b1; wait_q(Q/2);
    ack = ~sda_line;
    wait_q(Q/2);
    scl_drv = 1'b0; wait_q(Q);
  endtask

  initial begin
    logic ack;
    wait_q(3);
    chk("R1 reset", {24'h0, r0}, 32'h07);
    chk("R1 reset", {24'h0, r1}, 32'hFF);
    chk("R1 reset", {24'h0, r2}, 32'hFE);
    chk("R1 reset", {24'h0, r3}, 32'h00);
    chk("R1 reset", {24'h0, r4}, 32'hFF);
    chk("R5 idle sda", {31'h0, sda_oe}, 32'h0);
    rst_n = 1'b1;
    wait_q(4);
    chk_regs("R1 after release", {8'hFF, 8'h00, 8'hFE, 8'hFF, 8'h07});

    for (int v = 0; v < 5; v++) begin
      bus_start();
      send_byte(VECS[v].addr, ack);
      chk($sformatf("R2/R3 addr ack v%0d", v), {31'h0, ack}, {31'h0, VECS[v].ack});
      for (int k = 0; k < int'(VECS[v].nbytes); k++) begin
        send_byte(VECS[v].data[k], ack);
        chk($sformatf("R5/R6 data ack v%0d b%0d", v, k), {31'h0, ack}, {31'h0, VECS[v].ack});
      end
      bus_stop();
      chk_regs($sformatf("R3/R4/R6 regs v%0d", v), VECS[v].exp);
    end

    // R7: STOP after four bits of a data byte
    bus_start();
    send_byte(8'hD2, ack);
    chk("R7 addr ack", {31'h0, ack}, 32'h1);
    send_bits(8'hF0, 4);
    bus_stop();
    chk_regs("R7 mid-byte stop", {8'h55, 8'h44, 8'h33, 8'h22, 8'h80});

    // R8 R9: repeated START restarts at register 0
    bus_start();
    send_byte(8'hD2, ack);
    send_byte(8'h01, ack);
    chk("R9 visible before stop", {24'h0, r0}, 32'h01);
    send_byte(8'hC3, ack);
    bus_start();
    send_byte(8'hD2, ack);
    chk("R8 addr ack after restart", {31'h0, ack}, 32'h1);
    send_byte(8'h0F, ack);
    bus_stop();
    chk_regs("R8 repeated start", {8'h55, 8'h44, 8'h33, 8'hC3, 8'h0F});

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule